// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block produces the multiplexed external-bus strobes of an 8051-style machine cycle, counted in periods T of the oscillator clock. A machine cycle is twelve oscillator clocks, T1 through T12. The block drives the address-latch strobe, an active-low program-store strobe, active-low read and write strobes, the high address byte on port 2, and the low address byte and write data on port 0. It returns the bytes it captured from port 0, together with a one-clock done pulse.

A request is presented as a type, a 16-bit address, a write byte and an ALE-suppress control. The sequencer takes all four in T12 and carries out the matching access in the machine cycle that follows. A code fetch reads two bytes, at the address and at the address plus one. A data read or data write takes the place of the second fetch of its machine cycle. An idle cycle still pulses ALE at fosc/6 unless suppression is on. Suppression removes ALE only from cycles that make no external access.

Top module: `xbus_cycle_seq`

## Requirements
- R1: While reset is held, ale_o is 0, psen_n_o, rd_n_o and wr_n_o are 1, p0_oe_o is 0, p0_o is 0, done_o is 0 and rd_data_o is 0.
- R2: A machine cycle lasts 12 clocks. The request inputs (req_type_i: 00 idle, 01 code fetch, 10 data read, 11 data write) are sampled in T12 and executed in the next cycle. done_o is high for exactly the one clock after T12 of every non-idle cycle and is never high after an idle cycle.
- R3: With ALE suppression off, ale_o is high for two clocks in T1–T2 and again in T7–T8 of idle and fetch cycles.
- R4: With suppression on, idle cycles have no ALE pulse at all. Fetch cycles still pulse in T1–T2 and T7–T8, and data cycles still pulse in T1–T2.
- R5: Port 0 drives the low address byte during T2–T3 of every access. A fetch drives the low byte of the address plus one in T8–T9, with the sum wrapping within 16 bits.
- R6: A fetch drives psen_n_o low in T4–T6 and T10–T12. The byte on p0_in_i is taken at the end of T6 and at the end of T12, and rd_data_o = {second byte, first byte}.
- R7: In a data read or data write, rd_n_o or wr_n_o respectively is low for exactly T6–T11 (6 clocks), psen_n_o stays high for the whole cycle, and ALE pulses only in T1–T2.
- R8: In a data read, port 0 is released in T4–T12, the byte is taken at the end of T11, and rd_data_o = {8'h00, byte}.
- R9: In a data write, port 0 drives the write byte in T4–T12, covering the clock after wr_n_o rises, and rd_data_o becomes 16'h0000.
- R10: p2_o carries the high address byte: that of the address in fetch T1–T6 and in the whole of a data cycle, that of the address plus one in fetch T7–T12, and 8'h00 in idle cycles.
- R11: In an idle cycle, psen_n_o, rd_n_o and wr_n_o stay high, p0_oe_o is 0 and p0_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, one period per T |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| req_type_i | input | 2 | Request type for the next machine cycle |
| req_addr_i | input | 16 | Access address |
| req_wdata_i | input | 8 | Byte to write on a data write |
| ale_inhibit_i | input | 1 | Suppress ALE in cycles with no external access |
| p0_in_i | input | 8 | Port 0 value read back from the bus |
| ale_o | output | 1 | Address latch strobe |
| psen_n_o | output | 1 | Program store strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| p2_o | output | 8 | High address byte |
| p0_o | output | 8 | Low address byte or write data |
| p0_oe_o | output | 1 | Port 0 output enable |
| rd_data_o | output | 16 | Captured bytes from the last access |
| done_o | output | 1 | One-clock pulse after T12 of an access |

## Verification
The strobes and ports are decoded from the phase register and change directly after the clock edge that enters each T state. The bench holds its own T-state count, aligned on the first ALE rise after reset, and compares every output at the falling edge inside each T state. Requests are driven in T4 and are taken by the design at the edge that ends T12. rd_data_o and done_o are registered at that same edge, so the bench checks them at the falling edge of the following T1, against a queue of expected results filled by the driver. Port 0 read data comes from a bench memory that latches the address on the falling edge of ALE, which also confirms that the right address reaches the bus.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;
  localparam int CYC_LEN  = 12;
  localparam int HALF_LEN = CYC_LEN / 2;
  localparam int PH_W     = $clog2(CYC_LEN);
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int BYTE_W   = ADDR_W / 2;

  typedef logic [PH_W-1:0] ph_t;

  // phase indices count from 0 (T1) to CYC_LEN-1 (T12)
  localparam ph_t PH_LAST    = ph_t'(CYC_LEN - 1);
  localparam ph_t PH_HALF    = ph_t'(HALF_LEN);
  localparam ph_t ALE_END    = ph_t'(1);  // ALE high in half-phases 0..1
  localparam ph_t ADR_BEG    = ph_t'(1);  // low address 1 T before ALE falls
  localparam ph_t ADR_END    = ph_t'(2);  // and 1 T after
  localparam ph_t PSEN_BEG   = ph_t'(3);  // 3 T to half end
  localparam ph_t FETCH_SMP  = ph_t'(HALF_LEN - 1);
  localparam ph_t DSTB_BEG   = ph_t'(5);  // 3 T after ALE falls
  localparam ph_t DSTB_END   = ph_t'(10); // 6 T wide
  localparam ph_t WDAT_BEG   = ph_t'(3);

  typedef enum logic [1:0] {
    REQ_IDLE  = 2'b00,
    REQ_FETCH = 2'b01,
    REQ_READ  = 2'b10,
    REQ_WRITE = 2'b11
  } req_e;
endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr
  import xbus_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  output ph_t  ph_o,
  output logic last_o
);
  ph_t ph_q;
  ph_t ph_d;

  always_comb begin
    if (ph_q == PH_LAST) ph_d = '0;
    else                 ph_d = ph_q + ph_t'(1);
  end

  // reset parks the counter in T12 so the first full cycle starts cleanly
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) ph_q <= PH_LAST;
    else          ph_q <= ph_d;
  end

  assign ph_o   = ph_q;
  assign last_o = (ph_q == PH_LAST);
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbus_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  ph_t               ph_i,
  input  req_e              kind_i,
  input  logic              inhibit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [BYTE_W-1:0] p2_o,
  output logic [DATA_W-1:0] p0_o,
  output logic              p0_oe_o,
  output logic              ld_lo_o,
  output logic              ld_hi_o,
  output logic              clr_lo_o,
  output logic              clr_hi_o
);
  logic              second;
  ph_t               hp;
  logic              ale_win, adr_win, psen_win, dstb_win, wdat_win;
  logic [ADDR_W-1:0] addr_next, bus_addr;

  always_comb begin
    second    = (ph_i >= PH_HALF);
    hp        = second ? (ph_i - PH_HALF) : ph_i;
    ale_win   = (hp <= ALE_END);
    adr_win   = (hp >= ADR_BEG) && (hp <= ADR_END);
    psen_win  = (hp >= PSEN_BEG);
    dstb_win  = (ph_i >= DSTB_BEG) && (ph_i <= DSTB_END);
    wdat_win  = (ph_i >= WDAT_BEG);
    addr_next = addr_i + ADDR_W'(1);
    bus_addr  = (kind_i == REQ_FETCH && second) ? addr_next : addr_i;
  end

  always_comb begin
    ale_o    = 1'b0;
    psen_n_o = 1'b1;
    rd_n_o   = 1'b1;
    wr_n_o   = 1'b1;
    p2_o     = '0;
    p0_o     = '0;
    p0_oe_o  = 1'b0;
    ld_lo_o  = 1'b0;
    ld_hi_o  = 1'b0;
    clr_lo_o = 1'b0;
    clr_hi_o = 1'b0;
    unique case (kind_i)
      REQ_IDLE: begin
        ale_o = ale_win && !inhibit_i;
      end
      REQ_FETCH: begin
        ale_o    = ale_win;
        psen_n_o = !psen_win;
        p2_o     = bus_addr[ADDR_W-1 -: BYTE_W];
        if (adr_win) begin
          p0_oe_o = 1'b1;
          p0_o    = bus_addr[DATA_W-1:0];
        end
        ld_lo_o = (ph_i == FETCH_SMP);
        ld_hi_o = (ph_i == PH_LAST);
      end
      REQ_READ, REQ_WRITE: begin
        ale_o = ale_win && !second;
        p2_o  = addr_i[ADDR_W-1 -: BYTE_W];
        if (kind_i == REQ_READ) rd_n_o = !dstb_win;
        else                    wr_n_o = !dstb_win;
        if (adr_win && !second) begin
          p0_oe_o = 1'b1;
          p0_o    = addr_i[DATA_W-1:0];
        end else if (kind_i == REQ_WRITE && wdat_win) begin
          p0_oe_o = 1'b1;
          p0_o    = wdata_i;
        end
        ld_lo_o  = (kind_i == REQ_READ) && (ph_i == DSTB_END);
        clr_lo_o = (kind_i == REQ_WRITE) && (ph_i == DSTB_END);
        clr_hi_o = (ph_i == DSTB_END);
      end
      default: ;
    endcase
  end

  assert_one_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $countones({!psen_n_o, !rd_n_o, !wr_n_o}) <= 1);
  assert_bus_free_on_sample_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ld_lo_o || ld_hi_o) |-> !p0_oe_o);
  assert_ale_two_wide_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(ale_o) |=> ale_o);
  assert_ale_not_three_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ale_o && $past(ale_o)) |=> !ale_o);
  assert_rd_start_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(rd_n_o) |-> (ph_i == DSTB_BEG));
  assert_wr_end_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(wr_n_o) |-> (ph_i == DSTB_END + ph_t'(1)));
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
  import xbus_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                ld_lo_i,
  input  logic                ld_hi_i,
  input  logic                clr_lo_i,
  input  logic                clr_hi_i,
  input  logic                end_i,
  input  logic [DATA_W-1:0]   p0_in_i,
  output logic [2*DATA_W-1:0] rd_data_o,
  output logic                done_o
);
  logic [DATA_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              done_q, done_d;

  always_comb begin
    lo_d = lo_q;
    if (clr_lo_i)     lo_d = '0;
    else if (ld_lo_i) lo_d = p0_in_i;
    hi_d = hi_q;
    if (clr_hi_i)     hi_d = '0;
    else if (ld_hi_i) hi_d = p0_in_i;
    done_d = end_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      lo_q   <= '0;
      hi_q   <= '0;
      done_q <= 1'b0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      done_q <= done_d;
    end
  end

  assign rd_data_o = {hi_q, lo_q};
  assign done_o    = done_q;

  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |=> !done_o);
endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
  import xbus_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic [1:0]          req_type_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic                ale_inhibit_i,
  input  logic [DATA_W-1:0]   p0_in_i,
  output logic                ale_o,
  output logic                psen_n_o,
  output logic                rd_n_o,
  output logic                wr_n_o,
  output logic [BYTE_W-1:0]   p2_o,
  output logic [DATA_W-1:0]   p0_o,
  output logic                p0_oe_o,
  output logic [2*DATA_W-1:0] rd_data_o,
  output logic                done_o
);
  // reset asserts at once, releases on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ph_t  ph;
  logic last;

  xbus_phase_ctr u_phase (
    .clk_i  (clk_i),
    .rst_n_i(rst_sync_q),
    .ph_o   (ph),
    .last_o (last)
  );

  // request register, loaded in T12 only
  req_e              kind_q, kind_d;
  logic              inh_q, inh_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  always_comb begin
    kind_d  = kind_q;
    inh_d   = inh_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (last) begin
      kind_d  = req_e'(req_type_i);
      inh_d   = ale_inhibit_i;
      addr_d  = req_addr_i;
      wdata_d = req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      kind_q  <= REQ_IDLE;
      inh_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      kind_q  <= kind_d;
      inh_q   <= inh_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  logic ld_lo, ld_hi, clr_lo, clr_hi;

  xbus_strobe_gen u_strobe (
    .clk_i    (clk_i),
    .rst_n_i  (rst_sync_q),
    .ph_i     (ph),
    .kind_i   (kind_q),
    .inhibit_i(inh_q),
    .addr_i   (addr_q),
    .wdata_i  (wdata_q),
    .ale_o    (ale_o),
    .psen_n_o (psen_n_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o),
    .p2_o     (p2_o),
    .p0_o     (p0_o),
    .p0_oe_o  (p0_oe_o),
    .ld_lo_o  (ld_lo),
    .ld_hi_o  (ld_hi),
    .clr_lo_o (clr_lo),
    .clr_hi_o (clr_hi)
  );

  logic cycle_end;
  assign cycle_end = last && (kind_q != REQ_IDLE);

  xbus_capture u_capture (
    .clk_i    (clk_i),
    .rst_n_i  (rst_sync_q),
    .ld_lo_i  (ld_lo),
    .ld_hi_i  (ld_hi),
    .clr_lo_i (clr_lo),
    .clr_hi_i (clr_hi),
    .end_i    (cycle_end),
    .p0_in_i  (p0_in_i),
    .rd_data_o(rd_data_o),
    .done_o   (done_o)
  );

  assert_done_in_t1_R2: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    done_o |-> (ph == '0));
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (kind_q == REQ_IDLE) |-> (!p0_oe_o && psen_n_o && rd_n_o && wr_n_o));
  assert_psen_off_in_data_R7: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (kind_q == REQ_READ || kind_q == REQ_WRITE) |-> psen_n_o);
endmodule

// File: tb/xbus_cycle_seq_bench.sv
module xbus_cycle_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [1:0]  req_type;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        inhibit;
  logic [7:0]  p0_in;
  logic        ale, psen_n, rd_n, wr_n, p0_oe, done;
  logic [7:0]  p2, p0;
  logic [15:0] rd_data;

  int checks = 0;
  int errs   = 0;
  bit finished = 0;

  xbus_cycle_seq u_xbus_cycle_seq (
    .clk_i(clk), .rst_n_i(rst_n), .req_type_i(req_type), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .ale_inhibit_i(inhibit), .p0_in_i(p0_in),
    .ale_o(ale), .psen_n_o(psen_n), .rd_n_o(rd_n), .wr_n_o(wr_n), .p2_o(p2),
    .p0_o(p0), .p0_oe_o(p0_oe), .rd_data_o(rd_data), .done_o(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // external memory: low address latched on the falling ALE edge
  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction
  logic [7:0] ext_lat = 8'h00;
  always @(negedge ale) ext_lat = p0;
  assign p0_in = mem_byte({p2, ext_lat});

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected outputs per T state: {ale, psen_n, rd_n, wr_n, oe, p2, p0}
  function automatic logic [20:0] model(input int ph, input logic [1:0] k, input logic inh,
                                        input logic [15:0] a, input logic [7:0] d);
    logic e_ale, e_psn, e_rdn, e_wrn, e_oe;
    logic [7:0] e_p2, e_p0;
    logic [15:0] a2;
    int hp;
    bit sec;
    e_ale = 0; e_psn = 1; e_rdn = 1; e_wrn = 1; e_oe = 0; e_p2 = 0; e_p0 = 0;
    sec = (ph >= 6);
    hp  = sec ? ph - 6 : ph;
    a2  = (k == 2'b01 && sec) ? a + 16'd1 : a;
    case (k)
      2'b00: e_ale = (hp < 2) && !inh;
      2'b01: begin
        e_ale = (hp < 2);
        e_psn = !(hp >= 3);
        e_p2  = a2[15:8];
        if (hp == 1 || hp == 2) begin e_oe = 1; e_p0 = a2[7:0]; end
      end
      default: begin
        e_ale = (hp < 2) && !sec;
        e_p2  = a[15:8];
        if (k == 2'b10) e_rdn = !(ph >= 5 && ph <= 10);
        else            e_wrn = !(ph >= 5 && ph <= 10);
        if (ph == 1 || ph == 2) begin e_oe = 1; e_p0 = a[7:0]; end
        else if (k == 2'b11 && ph >= 3) begin e_oe = 1; e_p0 = d; end
      end
    endcase
    return {e_ale, e_psn, e_rdn, e_wrn, e_oe, e_p2, e_p0};
  endfunction

  // scoreboard
  logic [15:0] exp_q[$];
  logic [1:0]  kind_q[$];
  event        ph3_ev;

  task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d,
                       input logic inh);
    @(ph3_ev);
    req_type = k; req_addr = a; req_wdata = d; inhibit = inh;
    if (k == 2'b01) begin exp_q.push_back({mem_byte(a + 16'd1), mem_byte(a)}); kind_q.push_back(k); end
    if (k == 2'b10) begin exp_q.push_back({8'h00, mem_byte(a)}); kind_q.push_back(k); end
    if (k == 2'b11) begin exp_q.push_back(16'h0000); kind_q.push_back(k); end
  endtask

  // monitor: own T-state count, aligned on the first ALE rise after reset
  bit          synced = 0;
  int          bph = 0;
  logic [1:0]  bk = 0, bprev = 0;
  logic        binh = 0;
  logic [15:0] ba = 0;
  logic [7:0]  bd = 0;

  always @(negedge clk) begin
    logic [20:0] e;
    string t_ale, t_p0, t_oe, t_ps, t_dat;
    if (!synced && rst_n && ale) begin
      synced = 1;
      bph = 0;
    end
    if (synced) begin
      e = model(bph, bk, binh, ba, bd);
      t_ale = (binh) ? "R4" : "R3";
      t_ps  = (bk == 2'b01) ? "R6" : "R7";
      t_oe  = (bk == 2'b00) ? "R11" : (bk == 2'b10) ? "R8" : (bk == 2'b11) ? "R9" : "R5";
      t_p0  = (bk == 2'b11 && bph >= 3) ? "R9" : (bk == 2'b00) ? "R11" : "R5";
      chk(ale == e[20], t_ale, $sformatf("ale T%0d", bph + 1), 16'(ale), 16'(e[20]));
      chk(psen_n == e[19], t_ps, $sformatf("psen_n T%0d", bph + 1), 16'(psen_n), 16'(e[19]));
      chk(rd_n == e[18], "R7", $sformatf("rd_n T%0d", bph + 1), 16'(rd_n), 16'(e[18]));
      chk(wr_n == e[17], "R7", $sformatf("wr_n T%0d", bph + 1), 16'(wr_n), 16'(e[17]));
      chk(p0_oe == e[16], t_oe, $sformatf("p0_oe T%0d", bph + 1), 16'(p0_oe), 16'(e[16]));
      chk(p2 == e[15:8], "R10", $sformatf("p2 T%0d", bph + 1), 16'(p2), 16'(e[15:8]));
      chk(p0 == e[7:0], t_p0, $sformatf("p0 T%0d", bph + 1), 16'(p0), 16'(e[7:0]));
      if (bph == 0) begin
        chk(done == (bprev != 2'b00), "R2", "done in T1", 16'(done), 16'(bprev != 2'b00));
        if (done) begin
          if (exp_q.size() == 0) chk(0, "R2", "done with empty queue", 16'(done), 16'h0);
          else begin
            logic [15:0] x;
            logic [1:0]  kk;
            x  = exp_q.pop_front();
            kk = kind_q.pop_front();
            t_dat = (kk == 2'b01) ? "R6" : (kk == 2'b10) ? "R8" : "R9";
            chk(rd_data == x, t_dat, "rd_data", rd_data, x);
          end
        end
      end else begin
        chk(!done, "R2", $sformatf("done in T%0d", bph + 1), 16'(done), 16'h0);
      end
      if (bph == 3) -> ph3_ev;
      if (bph == 11) begin
        bprev = bk;
        bk = req_type; binh = inhibit; ba = req_addr; bd = req_wdata;
      end
      bph = (bph == 11) ? 0 : bph + 1;
    end
  end

  initial begin
    rst_n = 0; req_type = 2'b00; req_addr = 16'h0; req_wdata = 8'h0; inhibit = 0;
    repeat (3) @(negedge clk);
    chk(ale == 0, "R1", "ale in reset", 16'(ale), 16'h0);
    chk(psen_n && rd_n && wr_n, "R1", "strobes in reset", 16'({psen_n, rd_n, wr_n}), 16'h7);
    chk(!p0_oe && p0 == 0, "R1", "port0 in reset", 16'({p0_oe, p0}), 16'h0);
    chk(!done, "R1", "done in reset", 16'(done), 16'h0);
    chk(rd_data == 0, "R1", "rd_data in reset", rd_data, 16'h0);
    @(negedge clk);
    rst_n = 1;
    issue(2'b00, 16'h0000, 8'h00, 1'b0);  // idle, ALE free-running (R3)
    issue(2'b00, 16'h0000, 8'h00, 1'b1);  // idle, suppressed (R4)
    issue(2'b00, 16'h0000, 8'h00, 1'b1);
    issue(2'b01, 16'h12FF, 8'h00, 1'b1);  // fetch with carry, ALE kept (R4, R5, R10)
    issue(2'b01, 16'h0420, 8'h00, 1'b0);  // fetch (R6)
    issue(2'b10, 16'hA55A, 8'h00, 1'b0);  // read (R8)
    issue(2'b11, 16'h7F31, 8'hC3, 1'b1);  // write, suppression on (R9, R4)
    issue(2'b10, 16'h0001, 8'h00, 1'b1);  // back-to-back read (R7)
    issue(2'b01, 16'hFFFF, 8'h00, 1'b0);  // fetch wrapping to 0000 (R5)
    issue(2'b11, 16'h8000, 8'h5E, 1'b0);  // write (R9)
    issue(2'b00, 16'h0000, 8'h00, 1'b0);  // idle after access (R11, R2)
    issue(2'b00, 16'h0000, 8'h00, 1'b1);
    @(ph3_ev);
    @(ph3_ev);
    chk(exp_q.size() == 0, "R2", "outstanding results", 16'(exp_q.size()), 16'h0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL R2 watchdog: actual hung expected progress");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule